// File: doc/BRIEF.md
# Battery-Domain Wake Input Conditioner

This block takes seven wake inputs from the battery power domain and conditions them into one power-enable output. Each input passes through an optional three-sample glitch filter that runs on a 1 kHz tick. A per-input polarity bit then corrects the level, and an input-enable mask qualifies it. After that, a rising and falling edge detector keeps sticky status, and an optional per-input latch holds the input once it has been seen active. The reported state of each input is its latched value when latching is on for that input, and its live qualified value otherwise.

The power-enable output has two sources, chosen by a source bit in the control register. It follows either the OR of the reported input states or a bit that firmware owns. An 8-bit hold-off counter counts down in 125-tick units, and output assertion is blocked while it is non-zero. Edge detection can be gated separately for the phase when only the battery rail is up. Software reaches everything through a simple single-cycle register port. Writes are synchronous and the read data is combinational from the address.

Top module: `wake_ctl`

## Requirements
- R1: Register 0 is a read-only status word. It returns the reported input states in bits [6:0], the override input in bit 8, the registered power-enable in bit 9, the week alarm in bit 16 and the RTC alarm in bit 17. Every other bit reads 0, and after reset the whole word reads 0.
- R2: For an input whose bit is set in the latch-enable register (address 3), the reported state becomes 1 once the qualified input is active, and it stays 1 after the input goes inactive. Inputs without latching report the live qualified value.
- R3: A write to address 4 clears the latch of every input whose data bit is 1, and this clear wins over a set in the same cycle. Latches whose data bit is 0 keep their value. Address 4 reads 0.
- R4: Polarity register (address 5, reset value 0x7F): a bit value of 1 makes that input active high, and 0 makes it active low. Polarity is applied before latching and edge detection.
- R5: Control register (address 1) bit 2 controls the filter. When the bit is 0, the filtered level changes only after the raw input has differed from it on 3 consecutive tick samples. When the bit is 1, the raw input is used directly.
- R6: When control bit 1 is 1, the output source is control bit 0. When control bit 1 is 0, the output source is the OR of the reported input states.
- R7: Rising-edge status (address 6) and falling-edge status (address 7) are sticky per input. Writing 1 to a bit clears it, and writing 0 leaves it unchanged.
- R8: When `core_on` is 0, an edge is recorded only if that input's bit is set in the battery edge-enable register (address 8). When `core_on` is 1, that register has no effect.
- R9: A write to address 9 loads the 8-bit hold-off count. The count decrements once per 125 ticks while it is non-zero, and it reads back as the remaining count. While it is non-zero, `pwr_en` stays 0. Writing 0 removes the delay.
- R10: Input-enable register (address 2): an input whose bit is 0 reports 0, and it sets no edge status, no latch and no output request.
- R11: `pwr_en` is registered. It reflects the source and hold-off conditions one clock after they hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_ms | input | 1 | One-cycle 1 kHz time-base strobe |
| core_on | input | 1 | Core rail is powered |
| wake_in | input | 7 | Raw wake inputs |
| ovr_in | input | 1 | Override input level, reported in status |
| week_alarm | input | 1 | Week alarm flag |
| rtc_alarm | input | 1 | RTC alarm flag |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| pwr_en | output | 1 | Power-enable output |

## Verification
The bench drives short glitches into the filter and checks that they are rejected. A filter that counted samples without restarting would let such pulses through. It writes 0 to the edge-status registers and expects the bits to stay set, which catches a design that treats the status as plain write-to-load. It also checks the latch-reset bitmap bit by bit, since a design that cleared every latch would drop the unselected ones. The bench gates edges with the core rail both off and on, so a design that ignored the battery enable, or applied it all the time, records the wrong edges. The hold-off count is sampled part-way through, to show that the decrement rate is one per 125 ticks and that the output is held low until the count reaches zero.

// File: rtl/wake_pkg.sv
package wake_pkg;

    typedef enum logic [3:0] {
        A_STAT  = 4'd0,
        A_CTRL  = 4'd1,
        A_INEN  = 4'd2,
        A_LEN   = 4'd3,
        A_LRST  = 4'd4,
        A_POL   = 4'd5,
        A_RISE  = 4'd6,
        A_FALL  = 4'd7,
        A_BEDGE = 4'd8,
        A_HOLD  = 4'd9
    } reg_addr_e;

    typedef struct packed {
        logic filt_byp;
        logic src_fw;
        logic fw_val;
    } ctrl_t;

    localparam int ST_OVR  = 8;
    localparam int ST_OUT  = 9;
    localparam int ST_WEEK = 16;
    localparam int ST_RTC  = 17;

    function automatic logic apply_pol(input logic lvl, input logic act_hi);
        return act_hi ? lvl : ~lvl;
    endfunction

endpackage

// File: rtl/wake_filt.sv
module wake_filt #(
    parameter int LEN = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic bypass,
    input  logic raw,
    output logic cond
);
    localparam int CW = (LEN > 2) ? $clog2(LEN) : 1;

    logic [CW-1:0] cnt;
    logic          filt;

    always_ff @(posedge clk) begin
        if (rst) begin
            filt <= 1'b0;
            cnt  <= '0;
        end else if (tick) begin
            if (raw == filt) begin
                cnt <= '0;
            end else if (cnt == CW'(LEN - 1)) begin
                filt <= raw;
                cnt  <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    assign cond = bypass ? raw : filt;
endmodule

// File: rtl/wake_evt.sv
module wake_evt #(
    parameter int N = 7
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] qual,
    input  logic [N-1:0] edge_gate,
    input  logic [N-1:0] latch_en,
    input  logic [N-1:0] lat_clr,
    input  logic [N-1:0] rise_clr,
    input  logic [N-1:0] fall_clr,
    output logic [N-1:0] rise_sts,
    output logic [N-1:0] fall_sts,
    output logic [N-1:0] latched
);
    logic [N-1:0] prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev     <= '0;
            rise_sts <= '0;
            fall_sts <= '0;
            latched  <= '0;
        end else begin
            prev     <= qual;
            rise_sts <= (rise_sts & ~rise_clr) | (qual & ~prev & edge_gate);
            fall_sts <= (fall_sts & ~fall_clr) | (~qual & prev & edge_gate);
            latched  <= (latched | (qual & latch_en)) & ~lat_clr;
        end
    end
endmodule

// File: rtl/wake_hold.sv
module wake_hold #(
    parameter int CW  = 8,
    parameter int DIV = 125
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic [CW-1:0] count,
    output logic          zero
);
    localparam int PW = $clog2(DIV);

    logic [PW-1:0] pre;

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
            pre   <= '0;
        end else if (load) begin
            count <= load_val;
            pre   <= '0;
        end else if (tick && count != '0) begin
            if (pre == PW'(DIV - 1)) begin
                pre   <= '0;
                count <= count - 1'b1;
            end else begin
                pre <= pre + 1'b1;
            end
        end
    end

    assign zero = (count == '0);
endmodule

// File: rtl/wake_ctl.sv
module wake_ctl
    import wake_pkg::*;
#(
    parameter int N_IN     = 7,
    parameter int FILT_LEN = 3,
    parameter int HOLD_W   = 8,
    parameter int HOLD_DIV = 125
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            tick_ms,
    input  logic            core_on,
    input  logic [N_IN-1:0] wake_in,
    input  logic            ovr_in,
    input  logic            week_alarm,
    input  logic            rtc_alarm,
    input  logic            reg_wr,
    input  logic [3:0]      reg_addr,
    input  logic [31:0]     reg_wdata,
    output logic [31:0]     reg_rdata,
    output logic            pwr_en
);
    localparam logic [N_IN-1:0] ALL1 = '1;

    ctrl_t           ctrl;
    logic [N_IN-1:0] in_en, latch_en, pol, bedge;
    logic [N_IN-1:0] cond, qual, st, gate;
    logic [N_IN-1:0] rise_sts, fall_sts, latched;
    logic [N_IN-1:0] lat_clr, rise_clr, fall_clr;
    logic [N_IN-1:0] wd;
    logic [HOLD_W-1:0] hold_cnt;
    logic            hold_zero, out_req, pwr_q;
    logic [31:0]     status;
    logic            wdata_unused;

    assign wd           = reg_wdata[N_IN-1:0];
    assign wdata_unused = ^reg_wdata[31:N_IN];

    genvar gi;
    generate
        for (gi = 0; gi < N_IN; gi++) begin : g_in
            wake_filt #(.LEN(FILT_LEN)) u_filt (
                .clk    (clk),
                .rst    (rst),
                .tick   (tick_ms),
                .bypass (ctrl.filt_byp),
                .raw    (wake_in[gi]),
                .cond   (cond[gi])
            );
            assign qual[gi] = apply_pol(cond[gi], pol[gi]) & in_en[gi];
        end
    endgenerate

    assign gate     = in_en & (core_on ? ALL1 : bedge);
    assign lat_clr  = (reg_wr && reg_addr == A_LRST) ? wd : '0;
    assign rise_clr = (reg_wr && reg_addr == A_RISE) ? wd : '0;
    assign fall_clr = (reg_wr && reg_addr == A_FALL) ? wd : '0;

    wake_evt #(.N(N_IN)) u_evt (
        .clk       (clk),
        .rst       (rst),
        .qual      (qual),
        .edge_gate (gate),
        .latch_en  (latch_en),
        .lat_clr   (lat_clr),
        .rise_clr  (rise_clr),
        .fall_clr  (fall_clr),
        .rise_sts  (rise_sts),
        .fall_sts  (fall_sts),
        .latched   (latched)
    );

    wake_hold #(.CW(HOLD_W), .DIV(HOLD_DIV)) u_hold (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick_ms),
        .load     (reg_wr && reg_addr == A_HOLD),
        .load_val (reg_wdata[HOLD_W-1:0]),
        .count    (hold_cnt),
        .zero     (hold_zero)
    );

    assign st      = (latch_en & latched) | (~latch_en & qual);
    assign out_req = ctrl.src_fw ? ctrl.fw_val : (|st);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl     <= '0;
            in_en    <= '0;
            latch_en <= '0;
            pol      <= ALL1;
            bedge    <= '0;
            pwr_q    <= 1'b0;
        end else begin
            pwr_q <= out_req & hold_zero;
            if (reg_wr) begin
                case (reg_addr)
                    A_CTRL:  ctrl     <= ctrl_t'(reg_wdata[2:0]);
                    A_INEN:  in_en    <= wd;
                    A_LEN:   latch_en <= wd;
                    A_POL:   pol      <= wd;
                    A_BEDGE: bedge    <= wd;
                    default: ;
                endcase
            end
        end
    end

    assign pwr_en = pwr_q;

    always_comb begin
        status               = '0;
        status[N_IN-1:0]     = st;
        status[ST_OVR]       = ovr_in;
        status[ST_OUT]       = pwr_q;
        status[ST_WEEK]      = week_alarm;
        status[ST_RTC]       = rtc_alarm;
    end

    always_comb begin
        case (reg_addr)
            A_STAT:  reg_rdata = status;
            A_CTRL:  reg_rdata = 32'(ctrl);
            A_INEN:  reg_rdata = 32'(in_en);
            A_LEN:   reg_rdata = 32'(latch_en);
            A_POL:   reg_rdata = 32'(pol);
            A_RISE:  reg_rdata = 32'(rise_sts);
            A_FALL:  reg_rdata = 32'(fall_sts);
            A_BEDGE: reg_rdata = 32'(bedge);
            A_HOLD:  reg_rdata = 32'(hold_cnt);
            default: reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/wake_ctl_chk.sv
module wake_ctl_chk #(
    parameter int N  = 7,
    parameter int HW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          reg_wr,
    input logic [3:0]    reg_addr,
    input logic [31:0]   reg_wdata,
    input logic [31:0]   reg_rdata,
    input logic [N-1:0]  in_en,
    input logic [N-1:0]  rise_sts,
    input logic [N-1:0]  latched,
    input logic [HW-1:0] hold_cnt,
    input logic          src_fw,
    input logic          fw_val,
    input logic          pwr_en
);
    localparam logic [31:0] STAT_MASK = ((32'd1 << N) - 32'd1) | 32'h0003_0300;

    AST_HOLD_BLOCK: assert property (@(posedge clk) disable iff (rst)
        (hold_cnt != '0) |=> !pwr_en); // R9

    AST_FW_DRIVE: assert property (@(posedge clk) disable iff (rst)
        (src_fw && fw_val && hold_cnt == '0) |=> pwr_en); // R6

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == 4'd0) |-> ((reg_rdata & ~STAT_MASK) == 32'd0)); // R1

    AST_RISE_STICKY: assert property (@(posedge clk) disable iff (rst)
        !(reg_wr && reg_addr == 4'd6) |=> (($past(rise_sts) & ~rise_sts) == '0)); // R7

    AST_DIS_QUIET: assert property (@(posedge clk) disable iff (rst)
        ((rise_sts & ~$past(rise_sts) & ~$past(in_en)) == '0)); // R10

    AST_LAT_CLR: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == 4'd4) |=> ((latched & $past(reg_wdata[N-1:0])) == '0)); // R3
endmodule

bind wake_ctl wake_ctl_chk #(.N(N_IN), .HW(HOLD_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .in_en     (in_en),
    .rise_sts  (rise_sts),
    .latched   (latched),
    .hold_cnt  (hold_cnt),
    .src_fw    (ctrl.src_fw),
    .fw_val    (ctrl.fw_val),
    .pwr_en    (pwr_en)
);

// File: tb/wake_ctl_test.sv
module wake_ctl_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0, rst = 1'b1, tick_ms = 1'b0, core_on = 1'b1;
    logic [6:0]  wake_in = '0;
    logic        ovr_in = 1'b0, week_alarm = 1'b0, rtc_alarm = 1'b0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        pwr_en;

    int checks = 0, bad = 0, cyc_n = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wake_ctl uut (
        .clk(clk), .rst(rst), .tick_ms(tick_ms), .core_on(core_on),
        .wake_in(wake_in), .ovr_in(ovr_in), .week_alarm(week_alarm),
        .rtc_alarm(rtc_alarm), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pwr_en(pwr_en)
    );

    // ---------------- behavioural reference model ----------------
    logic [2:0] m_ctrl;
    logic [6:0] m_inen, m_len, m_pol, m_bedge, m_rise, m_fall, m_lat, m_prev, m_filt;
    int         m_fc[7];
    int         m_hold, m_pre;
    logic       m_pwr;

    function automatic logic [6:0] m_qual();
        logic [6:0] r;
        for (int i = 0; i < 7; i++) begin
            logic c;
            c = m_ctrl[2] ? wake_in[i] : m_filt[i];
            r[i] = (m_pol[i] ? c : !c) && m_inen[i];
        end
        return r;
    endfunction

    function automatic logic [6:0] m_state();
        logic [6:0] q, r;
        q = m_qual();
        for (int i = 0; i < 7; i++) r[i] = m_len[i] ? m_lat[i] : q[i];
        return r;
    endfunction

    function automatic logic [31:0] m_status();
        logic [31:0] s;
        s = '0;
        s[6:0] = m_state();
        s[8]   = ovr_in;
        s[9]   = m_pwr;
        s[16]  = week_alarm;
        s[17]  = rtc_alarm;
        return s;
    endfunction

    always @(posedge clk) begin : mdl
        logic [6:0] q, st, clr;
        logic       req;
        if (rst) begin
            m_ctrl = '0; m_inen = '0; m_len = '0; m_pol = 7'h7F; m_bedge = '0;
            m_rise = '0; m_fall = '0; m_lat = '0; m_prev = '0; m_filt = '0;
            for (int i = 0; i < 7; i++) m_fc[i] = 0;
            m_hold = 0; m_pre = 0; m_pwr = 0;
        end else begin
            q   = m_qual();
            st  = m_state();
            req = m_ctrl[1] ? m_ctrl[0] : (st != 0);
            for (int i = 0; i < 7; i++) begin
                bit g;
                g = m_inen[i] && (core_on || m_bedge[i]);
                clr = reg_wdata[6:0];
                if (reg_wr && reg_addr == 6 && clr[i]) m_rise[i] = 0;
                if (reg_wr && reg_addr == 7 && clr[i]) m_fall[i] = 0;
                if (g && q[i] && !m_prev[i]) m_rise[i] = 1;
                if (g && !q[i] && m_prev[i]) m_fall[i] = 1;
                if (q[i] && m_len[i]) m_lat[i] = 1;
                if (reg_wr && reg_addr == 4 && clr[i]) m_lat[i] = 0;
                if (tick_ms) begin
                    if (wake_in[i] == m_filt[i]) m_fc[i] = 0;
                    else if (m_fc[i] == 2) begin m_filt[i] = wake_in[i]; m_fc[i] = 0; end
                    else m_fc[i]++;
                end
            end
            m_prev = q;
            m_pwr  = req && (m_hold == 0);
            if (reg_wr && reg_addr == 9) begin
                m_hold = int'(reg_wdata[7:0]); m_pre = 0;
            end else if (tick_ms && m_hold != 0) begin
                if (m_pre == 124) begin m_pre = 0; m_hold--; end
                else m_pre++;
            end
            if (reg_wr) begin
                case (reg_addr)
                    1: m_ctrl  = reg_wdata[2:0];
                    2: m_inen  = reg_wdata[6:0];
                    3: m_len   = reg_wdata[6:0];
                    5: m_pol   = reg_wdata[6:0];
                    8: m_bedge = reg_wdata[6:0];
                    default: ;
                endcase
            end
        end
    end

    // ---------------- checking helpers ----------------
    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic tickc();
        @(negedge clk);
        if (!rst) begin
            chk("R6/R11 pwr_en vs model", 32'(pwr_en), 32'(m_pwr));
            if (reg_addr == 0) chk("R1 status vs model", reg_rdata, m_status());
        end
        cyc_n++;
        tick_ms = ((cyc_n % 4) == 0);
    endtask

    task automatic run(input int n);
        repeat (n) tickc();
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        tickc();
        reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] v);
        reg_addr = a;
        #1 v = reg_rdata;
        reg_addr = '0;
        #1;
    endtask

    task automatic pulse(input int b);
        wake_in[b] = 1'b1; run(2); wake_in[b] = 1'b0; run(2);
    endtask

    // ---------------- stimulus ----------------
    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        rd(0, v); chk("R1 reset status", v, 32'h0);
        chk("R11 reset pwr_en", 32'(pwr_en), 32'h0);
        rd(5, v); chk("R4 reset polarity", v, 32'h7F);

        wr(2, 32'h7F);
        wake_in[0] = 1'b1; run(5);
        rd(0, v); chk("R5 filter holds off", v & 32'h1, 32'h0);
        run(15);
        rd(0, v); chk("R5 filtered level", v & 32'h1, 32'h1);
        chk("R6 OR of inputs", 32'(pwr_en), 32'h1);
        rd(6, v); chk("R7 rise set", v, 32'h01);
        wr(6, 32'h0); rd(6, v); chk("R7 write 0 keeps", v, 32'h01);
        wr(6, 32'h1); rd(6, v); chk("R7 write 1 clears", v, 32'h0);

        wake_in[5] = 1'b1; run(3); wake_in[5] = 1'b0; run(20);
        rd(0, v); chk("R5 glitch rejected", v & 32'h20, 32'h0);
        rd(6, v); chk("R5 glitch no edge", v, 32'h0);

        wr(1, 32'h4);
        wr(2, 32'h7D);
        wake_in[0] = 1'b0; run(2);
        rd(7, v); chk("R7 fall set", v, 32'h01);
        chk("R6 no active input", 32'(pwr_en), 32'h0);
        wake_in[1] = 1'b1; run(3);
        rd(0, v); chk("R10 disabled reports 0", v & 32'h2, 32'h0);
        rd(6, v); chk("R10 disabled no edge", v, 32'h0);
        chk("R10 disabled no output", 32'(pwr_en), 32'h0);
        wake_in[1] = 1'b0; run(2);

        wr(5, 32'h7B); run(2);
        rd(0, v); chk("R4 active-low input", v & 32'h4, 32'h4);
        wr(5, 32'h7F); run(2);
        rd(0, v); chk("R4 active-high again", v & 32'h4, 32'h0);

        wr(3, 32'h08);
        pulse(3); run(1);
        rd(0, v); chk("R2 latched after input drops", v & 32'h8, 32'h8);
        chk("R2 latched drives output", 32'(pwr_en), 32'h1);
        wr(4, 32'h01);
        rd(0, v); chk("R3 unselected latch kept", v & 32'h8, 32'h8);
        rd(4, v); chk("R3 reset reg reads 0", v, 32'h0);
        wr(4, 32'h08);
        rd(0, v); chk("R3 selected latch cleared", v & 32'h8, 32'h0);
        wr(3, 32'h0);

        wr(6, 32'h7F); wr(7, 32'h7F);
        core_on = 1'b0; wr(8, 32'h0);
        pulse(4);
        rd(6, v); chk("R8 battery gate off", v, 32'h0);
        wr(8, 32'h10); pulse(4);
        rd(6, v); chk("R8 battery gate on", v, 32'h10);
        wr(6, 32'h7F); core_on = 1'b1; wr(8, 32'h0); pulse(4);
        rd(6, v); chk("R8 no effect with core on", v, 32'h10);
        wr(6, 32'h7F); wr(7, 32'h7F);

        ovr_in = 1'b1; week_alarm = 1'b1; rtc_alarm = 1'b1; run(3);
        rd(0, v); chk("R1 flag positions", v, 32'h0003_0100);
        ovr_in = 1'b0; week_alarm = 1'b0; rtc_alarm = 1'b0;

        wr(1, 32'h6); run(2);
        chk("R6 firmware low", 32'(pwr_en), 32'h0);
        wr(1, 32'h7);
        chk("R11 one cycle later", 32'(pwr_en), 32'h0);
        tickc();
        chk("R6 firmware high", 32'(pwr_en), 32'h1);
        rd(0, v); chk("R1 output bit", v & 32'h200, 32'h200);
        wr(1, 32'h6); wake_in[0] = 1'b1; run(3);
        chk("R6 inputs ignored in firmware mode", 32'(pwr_en), 32'h0);
        wake_in[0] = 1'b0;

        wr(1, 32'h7); run(2);
        wr(9, 32'h2); run(2);
        chk("R9 blocked", 32'(pwr_en), 32'h0);
        run(600);
        rd(9, v); chk("R9 count mid-way", v, 32'h1);
        run(300);
        chk("R9 still blocked", 32'(pwr_en), 32'h0);
        run(200);
        rd(9, v); chk("R9 count expired", v, 32'h0);
        chk("R9 released", 32'(pwr_en), 32'h1);
        wr(9, 32'h5); run(3);
        chk("R9 reload blocks", 32'(pwr_en), 32'h0);
        wr(9, 32'h0); run(2);
        chk("R9 zero disables", 32'(pwr_en), 32'h1);

        done = 1;
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; bad++;
            $display("FAIL watchdog act=timeout exp=finish");
            $display("  test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end
endmodule